// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block is the watchdog of a power-management controller. A host write loads three settings at once: the response mode, a timeout code that selects a period from 0.125 s to 4 s, and a flag that says whether the watchdog keeps running while the chip is in hibernation. Once armed, the watchdog counts down on a tick-enable strobe from an external timebase. Two things restart the count: a transition on the heartbeat pin and any host write to the settings.

When the count runs out, the block responds according to its mode. It can raise a timeout interrupt. It can instead raise a wake-reset interrupt together with a system reset request. In the third option it raises the interrupt on the first expiry and escalates to the reset on the second expiry, provided no restart arrives in between. Every output is a single-cycle pulse. The interrupt controller, the register bus decoder and the real-time timebase sit outside this block.

Top module: `wdg_top`

## Requirements
- R1: After a synchronous reset, the mode is off (00), the timeout code is 000 and the hibernate flag is 0. All three outputs are low.
- R2: In mode 01, `irq_timeout` pulses high for one cycle in the cycle after the tick that completes the period. The count then restarts and the next expiry comes one full period later.
- R3: In mode 10, `irq_wake_rst` and `sys_rst_req` pulse together for one cycle on each expiry. `irq_timeout` stays low.
- R4: In mode 11, the first expiry after a restart pulses `irq_timeout`. The count restarts, and the next expiry pulses `irq_wake_rst` with `sys_rst_req`. After that the sequence begins again with the interrupt. A heartbeat edge or a host write between the two expiries sends it back to the interrupt stage.
- R5: For codes 000 to 101, the period is `UNIT_TICKS << code` ticks. `UNIT_TICKS` ticks stand for 0.125 s, and each code step doubles the period.
- R6: Codes 110 and 111 never produce an expiry, whatever the mode.
- R7: While `hib_state` is high and the hibernate flag is 0, no expiry occurs and the count is held at the full period. With the flag set to 1, the watchdog runs in hibernation exactly as it does outside it.
- R8: A rising or a falling transition on `heartbeat` restarts the count and clears the escalation stage. The pin passes through a two-flop synchronizer, so the restart acts at the third clock edge after the pin changes.
- R9: A cycle with `host_wr` high loads the mode, code and flag. It also restarts the count with the period of the newly written code.
- R10: In mode 00 no output ever pulses. Whenever the watchdog is inactive (off, a reserved code, or gated by hibernation), the count is held at the full period, so it starts a complete period once it becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the settings; also restarts the count |
| host_mode | input | 2 | Mode written: 00 off, 01 interrupt, 10 reset, 11 escalate |
| host_code | input | 3 | Timeout code written (000 to 101 legal) |
| host_hib_en | input | 1 | Hibernate flag written: 1 keeps the watchdog running in hibernation |
| hib_state | input | 1 | High while the chip is in hibernation |
| heartbeat | input | 1 | Asynchronous heartbeat pin; either edge restarts the count |
| tick_en | input | 1 | Timebase strobe; one tick per high cycle |
| irq_timeout | output | 1 | Timeout interrupt pulse |
| irq_wake_rst | output | 1 | Wake-reset interrupt pulse |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The hardest case to reach is the second, resetting expiry of mode 11. It needs two full periods with no heartbeat edge and no host write. Random stimulus almost never produces that, because random kicks and writes keep landing inside the window. A directed segment therefore holds the heartbeat still and ticks every cycle through several interrupt and reset pairs. Another segment injects a heartbeat edge just after the first interrupt, to show that the stage falls back. A reference model in the bench tracks the three-edge synchronizer latency, so the long random phase can be compared against it cycle by cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WM_OFF    = 2'b00,
        WM_IRQ    = 2'b01,
        WM_RESET  = 2'b10,
        WM_ESCAL  = 2'b11
    } wdg_mode_e;

    localparam int unsigned CODE_MAX = 5;

    typedef struct packed {
        wdg_mode_e   mode;
        logic [2:0]  code;
        logic        hib_en;
    } wdg_cfg_t;

    function automatic logic code_legal(input logic [2:0] c);
        return c <= 3'(CODE_MAX);
    endfunction

    function automatic logic [2:0] code_clamp(input logic [2:0] c);
        return code_legal(c) ? c : 3'(CODE_MAX);
    endfunction

endpackage

// File: rtl/wdg_hb_edge.sv
module wdg_hb_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic edge_o
);
    localparam int unsigned NFF = SYNC_STAGES + 1;

    logic [NFF-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[NFF-2:0], pin};
    end

    assign edge_o = chain_q[NFF-1] ^ chain_q[NFF-2];

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          reload,
    input  logic          tick,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = active && !reload && tick && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= load_val;
        else if (reload || !active) cnt_q <= load_val;
        else if (tick)             cnt_q <= (cnt_q == CW'(1)) ? load_val : cnt_q - CW'(1);
    end

    a_r9_reload_loads: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == $past(load_val)));

    a_r5_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '0);

    a_r10_idle_holds_full: assert property (@(posedge clk) disable iff (rst)
        (!active && !reload) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    input  logic      clear,
    input  wdg_mode_e mode,
    output logic      irq_to,
    output logic      irq_wk,
    output logic      sys_rst
);
    logic first_q;
    logic to_d, wk_d;

    always_comb begin
        to_d = 1'b0;
        wk_d = 1'b0;
        if (expire) begin
            unique case (mode)
                WM_IRQ:   to_d = 1'b1;
                WM_RESET: wk_d = 1'b1;
                WM_ESCAL: begin
                    to_d = !first_q;
                    wk_d = first_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            irq_to  <= 1'b0;
            irq_wk  <= 1'b0;
            sys_rst <= 1'b0;
        end else begin
            irq_to  <= to_d;
            irq_wk  <= wk_d;
            sys_rst <= wk_d;
            if (clear)                            first_q <= 1'b0;
            else if (expire && mode == WM_ESCAL)  first_q <= !first_q;
        end
    end

    a_r4_reset_clears_stage: assert property (@(posedge clk) disable iff (rst)
        (irq_wk && mode == WM_ESCAL) |-> !first_q);

    a_r4_irq_arms_stage: assert property (@(posedge clk) disable iff (rst)
        (irq_to && mode == WM_ESCAL && !clear) |-> first_q);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_to |=> !irq_to);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> !sys_rst);

endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int unsigned UNIT_TICKS  = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [1:0] host_mode,
    input  logic [2:0] host_code,
    input  logic       host_hib_en,
    input  logic       hib_state,
    input  logic       heartbeat,
    input  logic       tick_en,
    output logic       irq_timeout,
    output logic       irq_wake_rst,
    output logic       sys_rst_req
);
    localparam int unsigned MAX_PERIOD = UNIT_TICKS << CODE_MAX;
    localparam int unsigned CW         = $clog2(MAX_PERIOD + 1);

    wdg_cfg_t      cfg_q;
    logic [CW-1:0] per_tab [CODE_MAX+1];
    logic [CW-1:0] load_val;
    logic          hb_edge, reload, active, expire;

    for (genvar i = 0; i <= CODE_MAX; i++) begin : g_period
        assign per_tab[i] = CW'(UNIT_TICKS << i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: WM_OFF, code: 3'b000, hib_en: 1'b0};
        end else if (host_wr) begin
            cfg_q <= '{mode: wdg_mode_e'(host_mode), code: host_code, hib_en: host_hib_en};
        end
    end

    assign reload   = host_wr || hb_edge;
    assign active   = (cfg_q.mode != WM_OFF) && code_legal(cfg_q.code)
                      && (!hib_state || cfg_q.hib_en);
    assign load_val = host_wr ? per_tab[code_clamp(host_code)] : per_tab[code_clamp(cfg_q.code)];

    wdg_hb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_hb (
        .clk    (clk),
        .rst    (rst),
        .pin    (heartbeat),
        .edge_o (hb_edge)
    );

    wdg_countdown #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .reload   (reload),
        .tick     (tick_en),
        .load_val (load_val),
        .expire   (expire)
    );

    wdg_escalate u_esc (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .clear   (reload || !active),
        .mode    (cfg_q.mode),
        .irq_to  (irq_timeout),
        .irq_wk  (irq_wake_rst),
        .sys_rst (sys_rst_req)
    );

    a_r7_hib_quiet: assert property (@(posedge clk) disable iff (rst)
        (hib_state && !cfg_q.hib_en) |=> !(irq_timeout || irq_wake_rst || sys_rst_req));

    a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        !code_legal(cfg_q.code) |=> !(irq_timeout || irq_wake_rst));

    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == WM_OFF) |=> !(irq_timeout || irq_wake_rst || sys_rst_req));

    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(irq_timeout && sys_rst_req));

endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
    localparam int unsigned UNIT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [1:0] host_mode = 2'b00;
    logic [2:0] host_code = 3'b000;
    logic       host_hib_en = 1'b0;
    logic       hib_state = 1'b0;
    logic       heartbeat = 1'b0;
    logic       tick_en = 1'b0;
    logic       irq_timeout, irq_wake_rst, sys_rst_req;

    int checks = 0;
    int errors = 0;
    int n_to = 0;
    int n_wk = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    wdg_top #(.UNIT_TICKS(UNIT)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_mode(host_mode),
        .host_code(host_code), .host_hib_en(host_hib_en), .hib_state(hib_state),
        .heartbeat(heartbeat), .tick_en(tick_en), .irq_timeout(irq_timeout),
        .irq_wake_rst(irq_wake_rst), .sys_rst_req(sys_rst_req)
    );

    function automatic int per(input logic [2:0] c);
        return (c > 3'd5) ? 1 : UNIT * (1 << c);
    endfunction

    // reference model built from the requirements
    logic [1:0] m_mode;
    logic [2:0] m_code;
    logic       m_hen, m_first, h1, h2, h3, e_to, e_wk;
    int         m_cnt;

    always @(posedge clk) begin
        logic edg, act, rl, ex;
        if (rst) begin
            m_mode = 0; m_code = 0; m_hen = 0; m_first = 0;
            h1 = 0; h2 = 0; h3 = 0; e_to = 0; e_wk = 0; m_cnt = per(0);
        end else begin
            edg  = h2 ^ h3;
            act  = (m_mode != 0) && (m_code <= 3'd5) && (!hib_state || m_hen);
            rl   = host_wr || edg;
            ex   = act && !rl && tick_en && (m_cnt == 1);
            e_to = ex && (m_mode == 2'd1 || (m_mode == 2'd3 && !m_first));
            e_wk = ex && (m_mode == 2'd2 || (m_mode == 2'd3 && m_first));
            if (rl || !act)               m_first = 0;
            else if (ex && m_mode == 2'd3) m_first = !m_first;
            if (host_wr) begin m_mode = host_mode; m_code = host_code; m_hen = host_hib_en; end
            if (rl || !act)  m_cnt = per(m_code);
            else if (tick_en) m_cnt = (m_cnt == 1) ? per(m_code) : m_cnt - 1;
            h3 = h2; h2 = h1; h1 = heartbeat;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk(irq_timeout == e_to,  tag, irq_timeout,  e_to);
        chk(irq_wake_rst == e_wk, tag, irq_wake_rst, e_wk);
        chk(sys_rst_req == e_wk,  tag, sys_rst_req,  e_wk);
        n_to += irq_timeout;
        n_wk += sys_rst_req;
    endtask

    task automatic wcfg(input logic [1:0] m, input logic [2:0] c, input logic h);
        host_wr = 1; host_mode = m; host_code = c; host_hib_en = h;
        cyc();
        host_wr = 0;
        n_to = 0; n_wk = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        tag = "R1";
        run(3);
        rst = 0;
        run(10);
        chk(n_to == 0 && n_wk == 0, "R1 reset quiet", n_to + n_wk, 0);

        tick_en = 1;
        tag = "R2";
        wcfg(2'b01, 3'd0, 0); run(20);
        chk(n_to == 10, "R2 count", n_to, 10);
        chk(n_wk == 0, "R2 no reset", n_wk, 0);

        tag = "R5";
        wcfg(2'b01, 3'd2, 0); run(40);
        chk(n_to == 5, "R5 period 8", n_to, 5);
        wcfg(2'b01, 3'd5, 0); run(128);
        chk(n_to == 2, "R5 period 64", n_to, 2);

        tag = "R3";
        wcfg(2'b10, 3'd1, 0); run(20);
        chk(n_wk == 5, "R3 resets", n_wk, 5);
        chk(n_to == 0, "R3 no irq", n_to, 0);

        tag = "R4";
        wcfg(2'b11, 3'd0, 0); run(8);
        chk(n_to == 2, "R4 irq count", n_to, 2);
        chk(n_wk == 2, "R4 reset count", n_wk, 2);
        wcfg(2'b11, 3'd1, 0); run(5);
        chk(n_to == 1 && n_wk == 0, "R4 first is irq", n_to, 1);
        heartbeat = ~heartbeat; run(5);
        chk(n_wk == 0, "R4 kick drops stage", n_wk, 0);
        run(4);
        chk(n_to == 2 && n_wk == 0, "R4 irq again after kick", n_to, 2);

        tag = "R8";
        wcfg(2'b01, 3'd1, 0);
        for (int i = 0; i < 20; i++) begin heartbeat = ~heartbeat; run(3); end
        chk(n_to == 0, "R8 both edges reload", n_to, 0);

        tag = "R9";
        wcfg(2'b01, 3'd1, 0);
        for (int i = 0; i < 20; i++) begin
            host_wr = 1; cyc(); host_wr = 0; run(2);
        end
        chk(n_to == 0, "R9 writes reload", n_to, 0);

        tag = "R6";
        wcfg(2'b11, 3'd6, 0); run(200);
        chk(n_to + n_wk == 0, "R6 code 6 silent", n_to + n_wk, 0);
        wcfg(2'b01, 3'd7, 1); run(200);
        chk(n_to + n_wk == 0, "R6 code 7 silent", n_to + n_wk, 0);

        tag = "R7";
        hib_state = 1;
        wcfg(2'b01, 3'd0, 0); run(50);
        chk(n_to == 0, "R7 gated in hibernation", n_to, 0);
        hib_state = 0; n_to = 0; run(2);
        chk(n_to == 1, "R7 full period after gate", n_to, 1);
        hib_state = 1;
        wcfg(2'b01, 3'd0, 1); run(50);
        chk(n_to == 25, "R7 runs with flag", n_to, 25);
        hib_state = 0;

        tag = "R10";
        wcfg(2'b00, 3'd0, 1); run(100);
        chk(n_to + n_wk == 0, "R10 off silent", n_to + n_wk, 0);

        tag = "R2 R3 R4 random";
        for (int i = 0; i < 6000; i++) begin
            tick_en   = ($urandom % 4) != 0;
            host_wr   = ($urandom % 80) == 0;
            host_mode = 2'($urandom);
            host_code = 3'($urandom % 7);
            host_hib_en = 1'($urandom);
            if (($urandom % 40) == 0)  heartbeat = ~heartbeat;
            if (($urandom % 300) == 0) hib_state = ~hib_state;
            cyc();
        end
        host_wr = 0;
        finish_up();
    end
endmodule